// File: doc/BRIEF.md
# Byte-Serial Multi-Cycle Instruction Sequencer

This block is the control and datapath heart of a small 8-bit accumulator processor. It reads its program one byte at a time from a synchronous byte-wide memory with a 14-bit address. Instructions are one, two or three bytes long and sit at consecutive addresses. Only the first byte, the opcode, is kept in a register. Each later byte is used in the cycle it arrives. It may go into the ALU, into a register, or into the staging byte for a jump target.

A step counter moves the work forward one cycle at a time. Each byte costs two steps. The first step puts the program counter on the address bus, copies it into the memory address register and advances it. The second step takes the returned byte. Combinational decode of the opcode and the step count produces every control signal. The counter goes back to zero after the last byte of an instruction.

The block holds an accumulator, two general registers B and C, and a carry flag. Its instruction set covers register moves, an 8-bit immediate add, a 16-bit immediate add on the B:C pair, absolute and relative jumps, and halt.

Top module: `byte_seq_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows a program counter of 0, a clear carry, a low `halted` and zero A, B and C, and the first fetch is issued from address 0.
- R2: Each byte takes two cycles. In the first cycle `mem_rd` is high and `mem_addr` equals the program counter, and the program counter goes up by one at the end of that cycle. In the second cycle `mem_rd` is low and the byte returned on `mem_rdata` is consumed.
- R3: Bits [7:6] of the opcode set the length. 00 means one byte, 01 means two bytes, and 10 or 11 means three bytes. An instruction therefore lasts 2, 4 or 6 cycles, and the next opcode is fetched right after it. An opcode not listed in R4 to R9 changes nothing except the program counter, which still skips its operand bytes.
- R4: 0x00 does nothing. 0x01 copies B into A. 0x02 copies C into A.
- R5: 0x40 followed by one data byte adds that byte to A. It writes the low 8 bits of the sum to A and the carry out to the carry flag.
- R6: 0x80 followed by a low byte and then a high byte adds a 16-bit value to B:C. First C plus the low byte, with no carry in, goes to C. Then B plus the high byte plus the carry from the first add goes to B. The carry flag ends as the carry out of the 16-bit sum.
- R7: 0x81 followed by a low byte and then a high byte jumps to the address formed by bits [5:0] of the high byte above the low byte. Bits [7:6] of the high byte are ignored.
- R8: 0x41 followed by a signed byte jumps to the address after the instruction plus that byte sign-extended, taken modulo 2^14.
- R9: 0x3F raises `halted` two cycles after its fetch starts. From then until reset, `halted` stays high, `mem_rd` stays low, and the program counter and registers do not change.
- R10: The carry flag changes only through 0x40 and 0x80. Moves, jumps, no-ops and undefined opcodes leave it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 14 | Memory byte address |
| mem_rd | output | 1 | Read strobe; the memory returns the byte the next cycle |
| mem_rdata | input | 8 | Byte returned by the memory |
| halted | output | 1 | High once a halt instruction has run |
| pc_out | output | 14 | Current program counter |
| acc_out | output | 8 | Accumulator |
| b_out | output | 8 | Register B |
| c_out | output | 8 | Register C |
| carry_out | output | 1 | Carry flag |

## Verification
The bench builds the core with its default 14-bit address. A bench memory of 1024 bytes is enough to put an absolute jump target at 0x100. It can also place a jump whose high byte carries set bits [7:6], which shows they are dropped. The test program covers these cases:
- a 16-bit add whose low-byte carry ripples through B and wraps B:C to zero;
- relative jumps both forward and backward;
- undefined opcodes of all three lengths.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int STEP_W = 3;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OP_NOP   = 8'h00;
    localparam logic [7:0] OP_MOVAB = 8'h01;
    localparam logic [7:0] OP_MOVAC = 8'h02;
    localparam logic [7:0] OP_HALT  = 8'h3F;
    localparam logic [7:0] OP_ADDI  = 8'h40;
    localparam logic [7:0] OP_JR    = 8'h41;
    localparam logic [7:0] OP_ADDBC = 8'h80;
    localparam logic [7:0] OP_JMP   = 8'h81;

    typedef enum logic [1:0] {ASRC_ALU, ASRC_B, ASRC_C} a_src_t;
    typedef enum logic [1:0] {LSEL_A, LSEL_B, LSEL_C} lsel_t;

    typedef struct packed {
        logic   fetch;
        logic   consume;
        logic   last;
        logic   op_ld;
        logic   halt_set;
        logic   wr_a;
        a_src_t a_src;
        lsel_t  lsel;
        logic   use_cin;
        logic   alu_en;
        logic   wr_b;
        logic   wr_c;
        logic   jlo_ld;
        logic   pc_abs;
        logic   pc_rel;
    } ctrl_t;

    // number of bytes an instruction occupies, from its two top opcode bits
    function automatic logic [1:0] op_bytes(input logic [7:0] op);
        case (op[7:6])
            2'b00:   return 2'd1;
            2'b01:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       halted,
    input  logic [7:0] rdata,
    output ctrl_t      ctl
);

    logic [STEP_W-1:0] step_q;
    logic [7:0]        op_q;
    logic [7:0]        cur_op;
    logic [1:0]        nbytes;
    logic [1:0]        idx;

    always_comb begin
        // in the opcode's own data step the byte has not been latched yet
        cur_op = (step_q == STEP_W'(1)) ? rdata : op_q;
        nbytes = op_bytes(cur_op);
        idx    = step_q[2:1];
        ctl    = '0;
        ctl.a_src = ASRC_ALU;
        ctl.lsel  = LSEL_A;
        if (!halted) begin
            ctl.fetch   = !step_q[0];
            ctl.consume = step_q[0];
            ctl.last    = step_q[0] && (idx == nbytes - 2'd1);
            ctl.op_ld   = step_q[0] && (idx == 2'd0);
            if (step_q[0]) begin
                case (idx)
                    2'd0: begin
                        case (cur_op)
                            OP_MOVAB: begin ctl.wr_a = 1'b1; ctl.a_src = ASRC_B; end
                            OP_MOVAC: begin ctl.wr_a = 1'b1; ctl.a_src = ASRC_C; end
                            OP_HALT:  ctl.halt_set = 1'b1;
                            default:  ;
                        endcase
                    end
                    2'd1: begin
                        case (cur_op)
                            OP_ADDI: begin
                                ctl.alu_en = 1'b1;
                                ctl.lsel   = LSEL_A;
                                ctl.wr_a   = 1'b1;
                                ctl.a_src  = ASRC_ALU;
                            end
                            OP_ADDBC: begin
                                ctl.alu_en = 1'b1;
                                ctl.lsel   = LSEL_C;
                                ctl.wr_c   = 1'b1;
                            end
                            OP_JR:   ctl.pc_rel = 1'b1;
                            OP_JMP:  ctl.jlo_ld = 1'b1;
                            default: ;
                        endcase
                    end
                    2'd2: begin
                        case (cur_op)
                            OP_ADDBC: begin
                                ctl.alu_en  = 1'b1;
                                ctl.lsel    = LSEL_B;
                                ctl.use_cin = 1'b1;
                                ctl.wr_b    = 1'b1;
                            end
                            OP_JMP:  ctl.pc_abs = 1'b1;
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.last) begin
            step_q <= '0;
        end else if (!halted) begin
            step_q <= step_q + STEP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= OP_NOP;
        end else if (ctl.op_ld) begin
            op_q <= rdata;
        end
    end

endmodule

// File: rtl/seq_alu.sv
module seq_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    always_comb begin
        {cout, sum} = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cin};
    end

endmodule

// File: rtl/seq_regs.sv
module seq_regs
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctl,
    input  logic [BYTE_W-1:0] rdata,
    input  logic [BYTE_W-1:0] alu_sum,
    input  logic              alu_cout,
    output logic [BYTE_W-1:0] a_q,
    output logic [BYTE_W-1:0] b_q,
    output logic [BYTE_W-1:0] c_q,
    output logic              cy_q,
    output logic [BYTE_W-1:0] jlo_q,
    output logic [BYTE_W-1:0] alu_lhs
);

    logic [BYTE_W-1:0] a_next;

    always_comb begin
        case (ctl.lsel)
            LSEL_B:  alu_lhs = b_q;
            LSEL_C:  alu_lhs = c_q;
            default: alu_lhs = a_q;
        endcase
        case (ctl.a_src)
            ASRC_B:  a_next = b_q;
            ASRC_C:  a_next = c_q;
            default: a_next = alu_sum;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
            cy_q  <= 1'b0;
            jlo_q <= '0;
        end else begin
            if (ctl.wr_a)   a_q   <= a_next;
            if (ctl.wr_b)   b_q   <= alu_sum;
            if (ctl.wr_c)   c_q   <= alu_sum;
            if (ctl.alu_en) cy_q  <= alu_cout;
            if (ctl.jlo_ld) jlo_q <= rdata;
        end
    end

endmodule

// File: rtl/byte_seq_core.sv
module byte_seq_core
    import seq_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_out,
    output logic [7:0]        acc_out,
    output logic [7:0]        b_out,
    output logic [7:0]        c_out,
    output logic              carry_out
);

    localparam int HI_W  = ADDR_W - BYTE_W;

    ctrl_t             ctl;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic              halt_q;
    logic [BYTE_W-1:0] alu_lhs;
    logic [BYTE_W-1:0] alu_sum;
    logic              alu_cout;
    logic [BYTE_W-1:0] jlo_q;
    logic [ADDR_W-1:0] rel_ext;

    seq_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .halted (halt_q),
        .rdata  (mem_rdata),
        .ctl    (ctl)
    );

    seq_alu #(.W(BYTE_W)) u_alu (
        .lhs  (alu_lhs),
        .rhs  (mem_rdata),
        .cin  (ctl.use_cin & carry_out),
        .sum  (alu_sum),
        .cout (alu_cout)
    );

    seq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .rdata    (mem_rdata),
        .alu_sum  (alu_sum),
        .alu_cout (alu_cout),
        .a_q      (acc_out),
        .b_q      (b_out),
        .c_q      (c_out),
        .cy_q     (carry_out),
        .jlo_q    (jlo_q),
        .alu_lhs  (alu_lhs)
    );

    assign rel_ext = {{HI_W{mem_rdata[7]}}, mem_rdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
        end else if (ctl.pc_abs) begin
            pc_q <= {mem_rdata[HI_W-1:0], jlo_q};
        end else if (ctl.pc_rel) begin
            pc_q <= pc_q + rel_ext;
        end else if (ctl.fetch) begin
            mar_q <= pc_q;
            pc_q  <= pc_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
        end else if (ctl.halt_set) begin
            halt_q <= 1'b1;
        end
    end

    assign mem_addr = ctl.fetch ? pc_q : mar_q;
    assign mem_rd   = ctl.fetch;
    assign halted   = halt_q;
    assign pc_out   = pc_q;

endmodule

// File: rtl/byte_seq_core_chk.sv
module byte_seq_core_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              halted,
    input logic [ADDR_W-1:0] pc_out,
    input logic [7:0]        acc_out,
    input logic              carry_out,
    input logic              alu_en
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pc_out == '0 && !halted && !carry_out && acc_out == 8'h00));

    p_read_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    p_pc_advance_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (pc_out == $past(pc_out) + ADDR_W'(1)));

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_no_read_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_rd);

    p_halt_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(pc_out) && $stable(acc_out)));

    p_carry_alu_only_r10: assert property (@(posedge clk) disable iff (rst)
        !alu_en |=> $stable(carry_out));

endmodule

bind byte_seq_core byte_seq_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rd    (mem_rd),
    .halted    (halted),
    .pc_out    (pc_out),
    .acc_out   (acc_out),
    .carry_out (carry_out),
    .alu_en    (ctl.alu_en)
);

// File: tb/byte_seq_core_test.sv
module byte_seq_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = 8'h00;
    logic        halted;
    logic [13:0] pc_out;
    logic [7:0]  acc_out, b_out, c_out;
    logic        carry_out;

    logic [7:0]  mem [0:1023];

    int checks = 0;
    int errors = 0;

    // behavioural machine state
    int m_pc, m_a, m_b, m_c, m_cy, m_halt;

    always #10 clk = ~clk;

    byte_seq_core uut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .pc_out    (pc_out),
        .acc_out   (acc_out),
        .b_out     (b_out),
        .c_out     (c_out),
        .carry_out (carry_out)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int len_of(input int op);
        if (op[7:6] == 2'b00) return 1;
        if (op[7:6] == 2'b01) return 2;
        return 3;
    endfunction

    // execute one whole instruction on the behavioural model
    task automatic iss_step();
        int p, op, b1, b2, n, s;
        p  = m_pc;
        op = mem[p[9:0]];
        n  = len_of(op);
        b1 = mem[(p + 1) & 10'h3FF];
        b2 = mem[(p + 2) & 10'h3FF];
        m_pc = (p + n) & 14'h3FFF;
        case (op)
            8'h01: m_a = m_b;
            8'h02: m_a = m_c;
            8'h3F: m_halt = 1;
            8'h40: begin s = m_a + b1; m_a = s & 8'hFF; m_cy = (s >> 8) & 1; end
            8'h80: begin
                s = m_c + b1; m_c = s & 8'hFF; m_cy = (s >> 8) & 1;
                s = m_b + b2 + m_cy; m_b = s & 8'hFF; m_cy = (s >> 8) & 1;
            end
            8'h81: m_pc = ((b2 & 8'h3F) << 8) | b1;
            8'h41: m_pc = (m_pc + ((b1 > 127) ? b1 - 256 : b1)) & 14'h3FFF;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int op);
        case (op)
            8'h00, 8'h01, 8'h02: return "R4";
            8'h40: return "R5";
            8'h80: return "R6";
            8'h81: return "R7";
            8'h41: return "R8";
            8'h3F: return "R9";
            default: return "R3";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p, op, n, frozen_pc;
        string t;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        // program
        mem[0]  = 8'h40; mem[1]  = 8'hF0;
        mem[2]  = 8'h40; mem[3]  = 8'h20;
        mem[4]  = 8'h01;
        mem[5]  = 8'h80; mem[6]  = 8'hFF; mem[7]  = 8'h00;
        mem[8]  = 8'h80; mem[9]  = 8'h01; mem[10] = 8'hFF;
        mem[11] = 8'h80; mem[12] = 8'h34; mem[13] = 8'h12;
        mem[14] = 8'h02;
        mem[15] = 8'h05;
        mem[16] = 8'h7E; mem[17] = 8'h99;
        mem[18] = 8'hC3; mem[19] = 8'h11; mem[20] = 8'h22;
        mem[21] = 8'h81; mem[22] = 8'h40; mem[23] = 8'h00;
        mem[10'h40] = 8'h41; mem[10'h41] = 8'h10;
        mem[10'h52] = 8'h40; mem[10'h53] = 8'h01;
        mem[10'h54] = 8'h41; mem[10'h55] = 8'hF0;
        mem[10'h46] = 8'h01;
        mem[10'h47] = 8'h81; mem[10'h48] = 8'h00; mem[10'h49] = 8'hC1;
        mem[10'h100] = 8'h80; mem[10'h101] = 8'hCC; mem[10'h102] = 8'h0B;
        mem[10'h103] = 8'h3F;

        m_pc = 0; m_a = 0; m_b = 0; m_c = 0; m_cy = 0; m_halt = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc_out == 14'd0, "R1 pc", pc_out, 0);
        chk(!halted && !carry_out, "R1 halted/carry", {halted, carry_out}, 0);
        chk(acc_out == 0 && b_out == 0 && c_out == 0, "R1 regs", {acc_out, b_out, c_out}, 0);
        chk(mem_rd && mem_addr == 14'd0, "R1 first fetch", mem_addr, 0);
        rst = 1'b0;

        for (int k = 0; k < 200 && m_halt == 0; k++) begin
            p  = m_pc;
            op = mem[p[9:0]];
            n  = len_of(op);
            for (int cy = 0; cy < 2 * n; cy++) begin
                if (cy % 2 == 0) begin
                    chk(mem_rd == 1'b1, "R2 read strobe", mem_rd, 1);
                    chk(mem_addr == 14'((p + cy / 2) & 14'h3FFF), "R2 address",
                        mem_addr, (p + cy / 2) & 14'h3FFF);
                end else begin
                    chk(mem_rd == 1'b0, "R2 data step", mem_rd, 0);
                end
                @(negedge clk);
            end
            iss_step();
            t = tag_of(op);
            chk(pc_out == 14'(m_pc), {t, " pc"}, pc_out, m_pc);
            chk(acc_out == 8'(m_a), {t, " acc"}, acc_out, m_a);
            chk(b_out == 8'(m_b), {t, " b"}, b_out, m_b);
            chk(c_out == 8'(m_c), {t, " c"}, c_out, m_c);
            chk(carry_out == 1'(m_cy), "R10 carry", carry_out, m_cy);
            chk(halted == 1'(m_halt), "R9 halted", halted, m_halt);
            if (m_halt == 0)
                chk(mem_rd && mem_addr == 14'(m_pc), "R3 next fetch", mem_addr, m_pc);
        end

        chk(m_halt == 1, "R9 program reached halt", m_halt, 1);
        frozen_pc = pc_out;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(halted && !mem_rd, "R9 stays halted", {halted, mem_rd}, 2);
            chk(pc_out == 14'(frozen_pc), "R9 pc frozen", pc_out, frozen_pc);
            chk(acc_out == 8'(m_a) && b_out == 8'(m_b), "R9 regs frozen", acc_out, m_a);
        end

        rst = 1'b1;
        @(negedge clk);
        chk(pc_out == 14'd0 && !halted, "R1 reset from halt", {halted, pc_out}, 0);
        chk(mem_rd && mem_addr == 14'd0, "R1 fetch restarts", mem_addr, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_rd && pc_out == 14'd1, "R2 after restart", pc_out, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule